// File: doc/BRIEF.md
# 8080-compatible ALU and flag unit

This block is the 8-bit arithmetic and logic stage of an 8080-style processor core, together with its packed flag byte. A decoder outside the block presents a 5-bit operation select, the accumulator, a second operand and the current flag byte. In the same cycle, without a clock, the block returns the 8-bit result and the next flag byte. Each operation changes only its own group of flags and passes the rest through unchanged. Carry after a subtraction means borrow. AND derives auxiliary carry from bit 3 of both inputs. Decimal adjust corrects a packed BCD sum.

A flag register holds the packed byte between instructions. It loads the new flag byte on a clock edge when the write enable is high and keeps its value otherwise. The three constant flag bits are forced on every path, whatever value arrives at the input.

Top module: `alu8080_unit`

## Requirements
- R1: Flag byte bits, from bit 7 down to bit 0: Sign, Zero, constant 0, Aux carry, constant 0, Parity, constant 1, Carry. On `flagsNext` and `flagsQ`, bits 5 and 3 are always 0 and bit 1 is always 1, whatever `flagsIn` holds.
- R2: opSel 0 (add) and 1 (add with carry-in). The result is acc + operand (+ Carry for code 1), modulo 256. Carry is the carry out of bit 7. Aux carry is the carry out of bit 3.
- R3: opSel 2 (subtract), 3 (subtract with borrow-in) and 4 (compare). The difference is acc − operand (− Carry for codes 3 and 4... only for code 3; compare uses no borrow-in). Carry is set when a borrow occurs. Aux carry is the carry out of bit 3 of acc + ~operand + (1 − borrow-in). For compare, `result` equals `accIn`.
- R4: opSel 5 (AND). The result is acc & operand. Carry is cleared. Aux carry is the OR of bit 3 of the two operands.
- R5: opSel 6 (XOR) and 7 (OR). Both clear Carry and Aux carry.
- R6: opSel 8 (increment) and 9 (decrement) act on `operand`. The result is operand ± 1, modulo 256, and Carry is left unchanged. Increment sets Aux carry when the low nibble was 0xF. Decrement sets Aux carry when the low nibble was not 0.
- R7: Every operation in R2–R6 and R11 sets Sign from result bit 7 and Zero when the result is 0. It sets Parity when the result has an even number of ones; for compare, this is the difference. Every other operation passes Sign, Zero and Parity through from `flagsIn`.
- R8: opSel 10 (complement). The result is ~acc, and every flag passes through from `flagsIn`.
- R9: opSel 11 forces Carry to 1 and opSel 12 inverts Carry. Both leave the result equal to acc and every other flag unchanged.
- R10: opSel 13 rotates left circular, 14 right circular, 15 left through Carry and 16 right through Carry. Carry receives the bit shifted out. No other flag changes.
- R11: opSel 17 (decimal adjust). First, 0x06 is added when the low nibble exceeds 9 or Aux carry is set; Aux carry becomes the carry out of bit 3 of that step, and 0 when no step is taken. Next, 0x60 is added when the high nibble of that sum exceeds 9 or Carry is set. Carry becomes 1 if either step carries out of bit 7 and otherwise keeps its value.
- R12: `flagsQ` is 0x02 while reset is asserted. It takes `flagsNext` on a rising clock edge when `flagWe` is 1 and holds its value when `flagWe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 5 | Operation select, codes 0 to 17 as in R2–R11 |
| accIn | input | 8 | Accumulator value |
| operand | input | 8 | Second operand, or the register to increment or decrement |
| flagsIn | input | 8 | Current packed flag byte |
| flagWe | input | 1 | Load enable of the flag register |
| result | output | 8 | Operation result |
| flagsNext | output | 8 | Next packed flag byte |
| flagsQ | output | 8 | Registered flag byte |

## Verification
The datapath holds no state, so a wrong carry select, aux-carry source or flag pass-through shows on `result` or `flagsNext` in the same evaluation as the bad input. The only stored state is the flag register. A stuck enable or a lost constant bit there shows on `flagsQ` one clock edge after the load, or after the hold, that should have happened. The sweeps cover every accumulator value with spread operands and four flag-input patterns. Each faulty flag rule therefore meets an input that exposes it.

// File: rtl/alu8080_pkg.sv
package alu8080_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;

  // bit positions in the packed flag byte
  localparam int FL_CY   = 0;
  localparam int FL_ONE  = 1;
  localparam int FL_PAR  = 2;
  localparam int FL_Z3   = 3;
  localparam int FL_AC   = 4;
  localparam int FL_Z5   = 5;
  localparam int FL_ZERO = 6;
  localparam int FL_SIGN = 7;

  localparam logic [DW-1:0] FLAG_ONES  = DW'(1 << FL_ONE);
  localparam logic [DW-1:0] FLAG_KEEP  = ~(DW'(1 << FL_Z3) | DW'(1 << FL_Z5) | FLAG_ONES);
  localparam logic [DW-1:0] FLAG_RESET = FLAG_ONES;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7,
    OP_INR = 5'd8,  OP_DCR = 5'd9,  OP_CPL = 5'd10, OP_STC = 5'd11,
    OP_CMC = 5'd12, OP_RLC = 5'd13, OP_RRC = 5'd14, OP_RAL = 5'd15,
    OP_RAR = 5'd16, OP_DAA = 5'd17
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_SUM, RS_AND, RS_XOR, RS_OR, RS_CPL, RS_ROT, RS_DAA, RS_PASS
  } resSel_e;

  typedef enum logic [2:0] {
    AC_KEEP, AC_SUM, AC_AND, AC_ZERO, AC_DAA
  } acMode_e;

  typedef enum logic [2:0] {
    CY_KEEP, CY_SUM, CY_BORROW, CY_ZERO, CY_SET, CY_INV, CY_ROT, CY_DAA
  } cyMode_e;

  typedef struct packed {
    resSel_e resSel;
    logic    invB;
    logic    useCin;
    logic    incDec;
    logic    isDec;
    logic    keepAcc;
    logic    wrSzp;
    acMode_e acMode;
    cyMode_e cyMode;
    logic    rotRight;
    logic    rotThru;
  } ctrl_t;
endpackage

// File: rtl/alu8080_ctrl.sv
module alu8080_ctrl
  import alu8080_pkg::*;
(
  input  logic [OPW-1:0] opSel,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl          = '0;
    ctrl.resSel   = RS_PASS;
    ctrl.acMode   = AC_KEEP;
    ctrl.cyMode   = CY_KEEP;
    case (aluOp_e'(opSel))
      OP_ADD, OP_ADC: begin
        ctrl.resSel = RS_SUM;
        ctrl.useCin = (aluOp_e'(opSel) == OP_ADC);
        ctrl.wrSzp  = 1'b1;
        ctrl.acMode = AC_SUM;
        ctrl.cyMode = CY_SUM;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        ctrl.resSel  = RS_SUM;
        ctrl.invB    = 1'b1;
        ctrl.useCin  = (aluOp_e'(opSel) == OP_SBB);
        ctrl.keepAcc = (aluOp_e'(opSel) == OP_CMP);
        ctrl.wrSzp   = 1'b1;
        ctrl.acMode  = AC_SUM;
        ctrl.cyMode  = CY_BORROW;
      end
      OP_AND: begin
        ctrl.resSel = RS_AND;
        ctrl.wrSzp  = 1'b1;
        ctrl.acMode = AC_AND;
        ctrl.cyMode = CY_ZERO;
      end
      OP_XOR, OP_OR: begin
        ctrl.resSel = (aluOp_e'(opSel) == OP_XOR) ? RS_XOR : RS_OR;
        ctrl.wrSzp  = 1'b1;
        ctrl.acMode = AC_ZERO;
        ctrl.cyMode = CY_ZERO;
      end
      OP_INR, OP_DCR: begin
        ctrl.resSel = RS_SUM;
        ctrl.incDec = 1'b1;
        ctrl.isDec  = (aluOp_e'(opSel) == OP_DCR);
        ctrl.wrSzp  = 1'b1;
        ctrl.acMode = AC_SUM;
      end
      OP_CPL: ctrl.resSel = RS_CPL;
      OP_STC: ctrl.cyMode = CY_SET;
      OP_CMC: ctrl.cyMode = CY_INV;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        ctrl.resSel   = RS_ROT;
        ctrl.cyMode   = CY_ROT;
        ctrl.rotRight = (aluOp_e'(opSel) == OP_RRC) || (aluOp_e'(opSel) == OP_RAR);
        ctrl.rotThru  = (aluOp_e'(opSel) == OP_RAL) || (aluOp_e'(opSel) == OP_RAR);
      end
      OP_DAA: begin
        ctrl.resSel = RS_DAA;
        ctrl.wrSzp  = 1'b1;
        ctrl.acMode = AC_DAA;
        ctrl.cyMode = CY_DAA;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8080_dp.sv
module alu8080_dp
  import alu8080_pkg::*;
(
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] flagsIn,
  output logic [DW-1:0] result,
  output logic [DW-1:0] flagsNext
);
  // shared adder: add, subtract, compare, increment, decrement
  logic [DW-1:0] aSide, bSide;
  logic          cin;
  always_comb begin
    if (ctrl.incDec) begin
      aSide = operand;
      bSide = ctrl.isDec ? '1 : '0;
      cin   = ~ctrl.isDec;
    end else begin
      aSide = accIn;
      bSide = ctrl.invB ? ~operand : operand;
      cin   = ctrl.useCin ? (flagsIn[FL_CY] ^ ctrl.invB) : ctrl.invB;
    end
  end

  logic [DW:0] sumW;
  logic [NW:0] nibW;
  assign sumW = {1'b0, aSide} + {1'b0, bSide} + {{DW{1'b0}}, cin};
  assign nibW = {1'b0, aSide[NW-1:0]} + {1'b0, bSide[NW-1:0]} + {{NW{1'b0}}, cin};

  // rotates
  logic          rotIn, rotOut;
  logic [DW-1:0] rotRes;
  always_comb begin
    rotOut = ctrl.rotRight ? accIn[0] : accIn[DW-1];
    rotIn  = ctrl.rotThru ? flagsIn[FL_CY] : rotOut;
    rotRes = ctrl.rotRight ? {rotIn, accIn[DW-1:1]} : {accIn[DW-2:0], rotIn};
  end

  // decimal adjust, two correction steps
  logic        lowAdj, hiAdj, daaCy;
  logic [NW:0] daaNib;
  logic [DW:0] daaStep1, daaStep2;
  always_comb begin
    lowAdj   = (accIn[NW-1:0] > NW'(9)) || flagsIn[FL_AC];
    daaNib   = {1'b0, accIn[NW-1:0]} + (lowAdj ? (NW+1)'(6) : '0);
    daaStep1 = {1'b0, accIn} + (lowAdj ? (DW+1)'(6) : '0);
    hiAdj    = (daaStep1[DW-1:NW] > NW'(9)) || flagsIn[FL_CY];
    daaStep2 = {1'b0, daaStep1[DW-1:0]} + (hiAdj ? (DW+1)'(6 << NW) : '0);
    daaCy    = flagsIn[FL_CY] | daaStep1[DW] | daaStep2[DW];
  end

  logic [DW-1:0] res;
  always_comb begin
    case (ctrl.resSel)
      RS_SUM:  res = sumW[DW-1:0];
      RS_AND:  res = accIn & operand;
      RS_XOR:  res = accIn ^ operand;
      RS_OR:   res = accIn | operand;
      RS_CPL:  res = ~accIn;
      RS_ROT:  res = rotRes;
      RS_DAA:  res = daaStep2[DW-1:0];
      default: res = accIn;
    endcase
  end

  logic acBit, cyBit;
  always_comb begin
    case (ctrl.acMode)
      AC_SUM:  acBit = nibW[NW];
      AC_AND:  acBit = accIn[NW-1] | operand[NW-1];
      AC_ZERO: acBit = 1'b0;
      AC_DAA:  acBit = daaNib[NW];
      default: acBit = flagsIn[FL_AC];
    endcase
    case (ctrl.cyMode)
      CY_SUM:    cyBit = sumW[DW];
      CY_BORROW: cyBit = ~sumW[DW];
      CY_ZERO:   cyBit = 1'b0;
      CY_SET:    cyBit = 1'b1;
      CY_INV:    cyBit = ~flagsIn[FL_CY];
      CY_ROT:    cyBit = rotOut;
      CY_DAA:    cyBit = daaCy;
      default:   cyBit = flagsIn[FL_CY];
    endcase
  end

  always_comb begin
    flagsNext = (flagsIn & FLAG_KEEP) | FLAG_ONES;
    if (ctrl.wrSzp) begin
      flagsNext[FL_SIGN] = res[DW-1];
      flagsNext[FL_ZERO] = (res == '0);
      flagsNext[FL_PAR]  = ~^res;
    end
    flagsNext[FL_AC] = acBit;
    flagsNext[FL_CY] = cyBit;
  end

  assign result = ctrl.keepAcc ? accIn : res;
endmodule

// File: rtl/alu8080_flagreg.sv
module alu8080_flagreg
  import alu8080_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   q <= FLAG_RESET;
    else if (we) q <= (d & FLAG_KEEP) | FLAG_ONES;
  end
endmodule

// File: rtl/alu8080_unit.sv
module alu8080_unit
  import alu8080_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [OPW-1:0] opSel,
  input  logic [DW-1:0]  accIn,
  input  logic [DW-1:0]  operand,
  input  logic [DW-1:0]  flagsIn,
  input  logic           flagWe,
  output logic [DW-1:0]  result,
  output logic [DW-1:0]  flagsNext,
  output logic [DW-1:0]  flagsQ
);
  ctrl_t ctrl;

  alu8080_ctrl u_ctrl (.opSel(opSel), .ctrl(ctrl));

  alu8080_dp u_dp (
    .ctrl(ctrl), .accIn(accIn), .operand(operand), .flagsIn(flagsIn),
    .result(result), .flagsNext(flagsNext)
  );

  alu8080_flagreg u_freg (
    .clk(clk), .rstN(rstN), .we(flagWe), .d(flagsNext), .q(flagsQ)
  );
endmodule

// File: rtl/alu8080_unit_chk.sv
module alu8080_unit_chk
  import alu8080_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic [OPW-1:0] opSel,
  input logic [DW-1:0]  accIn,
  input logic [DW-1:0]  operand,
  input logic [DW-1:0]  flagsIn,
  input logic           flagWe,
  input logic [DW-1:0]  result,
  input logic [DW-1:0]  flagsNext,
  input logic [DW-1:0]  flagsQ
);
  AST_FLAG_CONST: assert property (@(posedge clk) disable iff (!rstN)
    !flagsQ[FL_Z5] && !flagsQ[FL_Z3] && flagsQ[FL_ONE] &&
    !flagsNext[FL_Z5] && !flagsNext[FL_Z3] && flagsNext[FL_ONE]);  // R1

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CMP) |-> (result == accIn));  // R3

  AST_AND_CLR_CY: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_AND) |-> !flagsNext[FL_CY]);  // R4

  AST_ORX_CLR_CY_AC: assert property (@(posedge clk) disable iff (!rstN)
    ((opSel == OP_OR) || (opSel == OP_XOR)) |-> (!flagsNext[FL_CY] && !flagsNext[FL_AC]));  // R5

  AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rstN)
    ((opSel == OP_INR) || (opSel == OP_DCR)) |-> (flagsNext[FL_CY] == flagsIn[FL_CY]));  // R6

  AST_INR_AC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((opSel == OP_INR) && (operand[NW-1:0] != '1)) |-> !flagsNext[FL_AC]);  // R6

  AST_CPL_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CPL) |-> (flagsNext[FL_SIGN] == flagsIn[FL_SIGN] && flagsNext[FL_ZERO] == flagsIn[FL_ZERO] &&
                           flagsNext[FL_AC] == flagsIn[FL_AC] && flagsNext[FL_PAR] == flagsIn[FL_PAR] &&
                           flagsNext[FL_CY] == flagsIn[FL_CY]));  // R8

  AST_STC_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_STC) |-> (flagsNext[FL_CY] && result == accIn));  // R9

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |=> (flagsQ == $past(flagsNext)));  // R12

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable(flagsQ));  // R12
endmodule

bind alu8080_unit alu8080_unit_chk chk (.*);

// File: tb/tb_alu8080_unit.sv
module tb_alu8080_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] accIn = '0, operand = '0, flagsIn = '0;
  logic       flagWe = 1'b0;
  logic [7:0] result, flagsNext, flagsQ;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8080_unit dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .accIn(accIn), .operand(operand),
    .flagsIn(flagsIn), .flagWe(flagWe), .result(result), .flagsNext(flagsNext), .flagsQ(flagsQ)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h f=%02h actual=%02h expected=%02h",
               req, what, opSel, accIn, operand, flagsIn, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  function automatic string reqOf(input int op);
    case (op)
      0, 1:           return "R2";
      2, 3, 4:        return "R3";
      5:              return "R4";
      6, 7:           return "R5";
      8, 9:           return "R6";
      10:             return "R8";
      11, 12:         return "R9";
      13, 14, 15, 16: return "R10";
      default:        return "R11";
    endcase
  endfunction

  // reference model: returns {result, flags}
  function automatic logic [15:0] model(input int op, input int a, input int b, input logic [7:0] f);
    int r, cy, ac, c, s, t;
    bit upd;
    logic [7:0] rr, fl;
    r = a; cy = f[0]; ac = f[4]; upd = 0;
    case (op)
      0, 1: begin
        c = (op == 1) ? int'(f[0]) : 0;
        s = a + b + c; r = s & 255; cy = (s >> 8) & 1;
        ac = (((a & 15) + (b & 15) + c) >> 4) & 1; upd = 1;
      end
      2, 3, 4: begin
        c = (op == 3) ? int'(f[0]) : 0;
        s = a - b - c; r = s & 255; cy = (s < 0) ? 1 : 0;
        ac = (((a & 15) + ((~b) & 15) + (1 - c)) >> 4) & 1; upd = 1;
      end
      5: begin r = a & b; cy = 0; ac = ((a | b) >> 3) & 1; upd = 1; end
      6: begin r = a ^ b; cy = 0; ac = 0; upd = 1; end
      7: begin r = a | b; cy = 0; ac = 0; upd = 1; end
      8: begin r = (b + 1) & 255; ac = ((b & 15) == 15) ? 1 : 0; upd = 1; end
      9: begin r = (b + 255) & 255; ac = ((b & 15) != 0) ? 1 : 0; upd = 1; end
      10: r = (~a) & 255;
      11: cy = 1;
      12: cy = 1 - int'(f[0]);
      13: begin r = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; end
      14: begin r = (a >> 1) | ((a & 1) << 7); cy = a & 1; end
      15: begin r = ((a << 1) | int'(f[0])) & 255; cy = a >> 7; end
      16: begin r = (a >> 1) | (int'(f[0]) << 7); cy = a & 1; end
      default: begin
        t = a; ac = 0;
        if (((a & 15) > 9) || f[4]) begin
          ac = (((a & 15) + 6) > 15) ? 1 : 0;
          t = a + 6;
        end
        if (t > 255) cy = 1;
        t = t & 255;
        if (((t >> 4) > 9) || f[0]) begin
          t = t + 8'h60;
          if (t > 255) cy = 1;
        end
        r = t & 255; upd = 1;
      end
    endcase
    rr = r[7:0];
    fl = 8'h02;
    fl[7] = upd ? rr[7] : f[7];
    fl[6] = upd ? (rr == 0) : f[6];
    fl[2] = upd ? ($countones(rr) % 2 == 0) : f[2];
    fl[4] = ac[0];
    fl[0] = cy[0];
    return {(op == 4) ? a[7:0] : rr, fl};
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired before the run ended");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] fPat [4];
    logic [15:0] exp;
    fPat[0] = 8'h00; fPat[1] = 8'h11; fPat[2] = 8'hC4; fPat[3] = 8'hFF;

    // R12: reset value
    repeat (2) @(posedge clk);
    #1 check("R12", "reset flagsQ", flagsQ, 8'h02);
    @(negedge clk) rstN = 1'b1;

    // R12: load through STC
    opSel = 5'd11; flagsIn = 8'h00; flagWe = 1'b1;
    @(posedge clk); #1 check("R12", "load flagsQ", flagsQ, 8'h03);
    // R12: hold with enable low
    @(negedge clk) flagWe = 1'b0; opSel = 5'd0; flagsIn = 8'hFF; accIn = 8'h80; operand = 8'h80;
    @(posedge clk); #1 check("R12", "hold flagsQ", flagsQ, 8'h03);
    // R1: constant bits forced on load
    @(negedge clk) opSel = 5'd10; flagsIn = 8'hFF; flagWe = 1'b1;
    @(posedge clk); #1 check("R1", "const bits flagsQ", flagsQ, 8'hD7);
    @(negedge clk) flagWe = 1'b0;

    // combinational sweeps
    for (int op = 0; op < 18; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 15) begin
          for (int k = 0; k < 4; k++) begin
            opSel = op[4:0]; accIn = a[7:0]; operand = b[7:0]; flagsIn = fPat[k];
            #1;
            exp = model(op, a, b, fPat[k]);
            check(reqOf(op), "result", result, exp[15:8]);
            check(reqOf(op), "carry/aux", flagsNext & 8'h11, exp[7:0] & 8'h11);
            check("R7", "sign/zero/parity", flagsNext & 8'hC4, exp[7:0] & 8'hC4);
            check("R1", "const bits", flagsNext & 8'h2A, 8'h02);
          end
        end
      end
    end

    // R12: asynchronous reset returns to 0x02
    @(negedge clk) opSel = 5'd11; flagWe = 1'b1;
    @(posedge clk); #1;
    rstN = 1'b0; #1 check("R12", "async reset flagsQ", flagsQ, 8'h02);

    finished = 1;
    summary();
    $finish;
  end
endmodule